// File: doc/BRIEF.md
# Multi-Event Packet Assembler

This block sits on a detector readout board, after the stage that formats each triggered event into a byte fragment. It gathers the fragments of consecutive events and sends them out as one combined packet, so the per-packet header cost is spread over several events. The number of events per packet comes from a configuration input. A packing factor of zero counts as one, and values above the supported maximum are clamped to that maximum.

The destination node of each packet is not chosen here. It arrives from the timing network on a valid/ready channel, and one identifier is consumed per packet. Packets leave on a byte-wide valid/ready stream and are never acknowledged or resent. A registered throttle output warns the trigger supervisor when the byte store is close to full, and releases it with hysteresis.

Top module: `mep_assembler`

## Requirements
- R1: After reset, out_valid, dest_ready and throttle are low and in_ready is high.
- R2: The effective packing factor N is cfg_pack. A value of 0 gives N = 1, and a value above MAX_PACK (8) gives N = MAX_PACK. Each packet holds exactly N consecutive events.
- R3: A packet does not start until all N of its fragments have been fully received, meaning the byte marked in_last of the Nth fragment has been accepted. Until then, out_valid and dest_ready stay low.
- R4: A packet opens with a 4-byte header. Byte 0 is the destination identifier, byte 1 is N, and bytes 2 and 3 are the 16-bit number of the packet's first event, high byte first. Events are numbered from 0 after reset and increase by one per fragment.
- R5: After the header, each fragment follows in arrival order. A fragment is one length byte (1 to 255, the number of payload bytes) followed by its payload bytes. out_last marks only the final payload byte of the packet.
- R6: Destination identifiers are used in arrival order, one per packet. dest_ready is high only while the block is idle and N complete events are stored. A packet with no identifier available is held with out_valid low. The accepted identifier appears as the first output byte in the next cycle.
- R7: While out_valid is high and out_ready is low, out_data and out_last hold their values. Within a packet, out_valid stays high until the out_last byte has been transferred.
- R8: throttle rises one cycle after the stored payload exceeds BUF_DEPTH − FRAG_MAX·MAX_PACK bytes (more than 128). It falls only once the stored payload is at most BUF_DEPTH − FRAG_MAX·MAX_PACK − HYST bytes (96 or less).
- R9: in_ready is low while the payload store holds BUF_DEPTH (256) bytes or the length store holds LEN_DEPTH (16) complete fragments. No accepted byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pack | input | CFG_W (4) | Requested events per packet |
| in_valid | input | 1 | Fragment byte valid |
| in_ready | output | 1 | Fragment byte accepted when high with in_valid |
| in_data | input | 8 | Fragment byte |
| in_last | input | 1 | Marks the final byte of a fragment |
| dest_valid | input | 1 | Destination identifier valid |
| dest_ready | output | 1 | Destination identifier taken |
| dest_id | input | 8 | Destination node identifier |
| out_valid | output | 1 | Packet byte valid |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Packet byte |
| out_last | output | 1 | Final byte of the packet |
| throttle | output | 1 | Store nearly full, stop triggers |

## Verification
Two things can happen in the same cycle: a new fragment byte can be written into the store while a payload byte of an earlier packet is read out. The occupancy then has to move both ways at once, and the throttle decision depends on it. A randomized phase makes this overlap common. It sends back-to-back fragments while out_ready and the destination supply toggle at random. Every packet is then compared byte by byte with a model built from the fragments sent, and a directed fill-and-drain sequence pins the throttle thresholds to exact payload counts.

// File: rtl/mep_assembler.sv
module mep_assembler #(
  parameter int BUF_DEPTH = 256,
  parameter int LEN_DEPTH = 16,
  parameter int FRAG_MAX  = 16,
  parameter int MAX_PACK  = 8,
  parameter int HYST      = 32,
  parameter int CFG_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_pack,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic             dest_valid,
  output logic             dest_ready,
  input  logic [7:0]       dest_id,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             throttle
);
  localparam int AW      = $clog2(BUF_DEPTH);
  localparam int LW      = $clog2(LEN_DEPTH);
  localparam int CW      = $clog2(BUF_DEPTH + 1);
  localparam int NW      = $clog2(MAX_PACK + 1);
  localparam int THR_ON  = FRAG_MAX * MAX_PACK;
  localparam int THR_OFF = THR_ON + HYST;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_LEN, S_PAY} st_t;

  logic [7:0]    mem  [BUF_DEPTH];
  logic [7:0]    lmem [LEN_DEPTH];
  logic [AW-1:0] wr, rd;
  logic [LW-1:0] lwr, lrd;
  logic [CW-1:0] dcnt;
  logic [LW:0]   lcnt;
  logic [7:0]    flen, rem, cur_dest;
  logic [NW-1:0] eff, cur_n, evleft;
  logic [15:0]   evnum, first;
  logic [1:0]    hidx;
  st_t           st;

  always_comb begin
    if (cfg_pack == '0)                      eff = NW'(1);
    else if (int'(cfg_pack) > MAX_PACK)      eff = NW'(MAX_PACK);
    else                                     eff = NW'(cfg_pack);
  end

  wire enough   = int'(lcnt) >= int'(eff);
  wire in_fire  = in_valid & in_ready;
  wire out_fire = out_valid & out_ready;
  wire pay_fire = out_fire & (st == S_PAY);
  wire frag_end = pay_fire & (rem == 8'd1);
  wire start    = dest_valid & dest_ready;

  assign in_ready   = (int'(dcnt) != BUF_DEPTH) && (int'(lcnt) != LEN_DEPTH);
  assign dest_ready = (st == S_IDLE) && enough;
  assign out_valid  = (st != S_IDLE);
  assign out_last   = (st == S_PAY) && (rem == 8'd1) && (evleft == NW'(1));

  always_comb begin
    out_data = 8'h00;
    case (st)
      S_HDR: case (hidx)
               2'd0:    out_data = cur_dest;
               2'd1:    out_data = 8'(cur_n);
               2'd2:    out_data = first[15:8];
               default: out_data = first[7:0];
             endcase
      S_LEN: out_data = lmem[lrd];
      S_PAY: out_data = mem[rd];
      default: out_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (in_fire) begin
      mem[wr] <= in_data;
      if (in_last) lmem[lwr] <= flen + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr   <= '0;
      lwr  <= '0;
      flen <= '0;
    end else if (in_fire) begin
      wr <= wr + AW'(1);
      if (in_last) begin
        lwr  <= lwr + LW'(1);
        flen <= '0;
      end else begin
        flen <= flen + 8'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcnt <= '0;
      lcnt <= '0;
    end else begin
      dcnt <= dcnt + CW'(in_fire) - CW'(pay_fire);
      lcnt <= lcnt + (LW+1)'(in_fire & in_last) - (LW+1)'(frag_end);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      rd       <= '0;
      lrd      <= '0;
      rem      <= '0;
      hidx     <= '0;
      evleft   <= '0;
      cur_n    <= '0;
      cur_dest <= '0;
      first    <= '0;
      evnum    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cur_dest <= dest_id;
          cur_n    <= eff;
          evleft   <= eff;
          first    <= evnum;
          evnum    <= evnum + 16'(eff);
          hidx     <= '0;
          st       <= S_HDR;
        end
        S_HDR: if (out_fire) begin
          hidx <= hidx + 2'd1;
          if (hidx == 2'd3) st <= S_LEN;
        end
        S_LEN: if (out_fire) begin
          rem <= lmem[lrd];
          st  <= S_PAY;
        end
        default: if (out_fire) begin
          rd  <= rd + AW'(1);
          rem <= rem - 8'd1;
          if (rem == 8'd1) begin
            lrd    <= lrd + LW'(1);
            evleft <= evleft - NW'(1);
            st     <= (evleft == NW'(1)) ? S_IDLE : S_LEN;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      throttle <= 1'b0;
    else if (!throttle && int'(dcnt) > BUF_DEPTH - THR_ON)
      throttle <= 1'b1;
    else if (throttle && int'(dcnt) <= BUF_DEPTH - THR_OFF)
      throttle <= 1'b0;
  end
endmodule

// File: rtl/mep_assembler_chk.sv
module mep_assembler_chk #(
  parameter int BUF_DEPTH = 256,
  parameter int FRAG_MAX  = 16,
  parameter int MAX_PACK  = 8,
  parameter int HYST      = 32,
  parameter int CW        = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          dest_valid,
  input logic          dest_ready,
  input logic [7:0]    dest_id,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic          out_last,
  input logic          throttle,
  input logic [CW-1:0] dcnt
);
  localparam int LIM_ON  = BUF_DEPTH - FRAG_MAX * MAX_PACK;
  localparam int LIM_OFF = LIM_ON - HYST;

  a_r6_dest_first: assert property (@(posedge clk) disable iff (!rst_n)
    dest_valid && dest_ready |=> out_valid && out_data == $past(dest_id));

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  a_r7_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid);

  a_r8_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(throttle) |-> int'($past(dcnt)) > LIM_ON);

  a_r8_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(throttle) |-> int'($past(dcnt)) <= LIM_OFF);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(dcnt) <= BUF_DEPTH);

  a_r9_full_block: assert property (@(posedge clk) disable iff (!rst_n)
    int'(dcnt) == BUF_DEPTH |-> !in_ready);
endmodule

bind mep_assembler mep_assembler_chk #(
  .BUF_DEPTH(BUF_DEPTH), .FRAG_MAX(FRAG_MAX), .MAX_PACK(MAX_PACK),
  .HYST(HYST), .CW($clog2(BUF_DEPTH + 1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .dest_valid(dest_valid), .dest_ready(dest_ready), .dest_id(dest_id),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .throttle(throttle), .dcnt(dcnt)
);

// File: tb/mep_assembler_tb.sv
`timescale 1ns/1ps
module mep_assembler_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_pack = 4'd1;
  logic       in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       dest_valid = 1'b0;
  logic [7:0] dest_id = 8'h00;
  logic       dest_ready;
  logic       out_valid, out_last, throttle;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  mep_assembler u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_pack(cfg_pack),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .dest_valid(dest_valid), .dest_ready(dest_ready), .dest_id(dest_id),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .throttle(throttle)
  );

  int checks = 0, fails = 0;
  logic [7:0] ev_data[$];
  int         ev_off[$], ev_len[$];
  int         next_ev = 0;
  logic [7:0] exp_q[$], got_q[$], dest_q[$];
  bit         exp_l[$], got_l[$];
  bit         dest_en = 1'b1, rnd_dest = 1'b0, rnd_ready = 1'b0, ready_force = 1'b1;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int eff_of(int c);
    if (c == 0) return 1;
    if (c > 8) return 8;
    return c;
  endfunction

  function automatic void build_packet(int n, logic [7:0] d);
    exp_q.push_back(d);               exp_l.push_back(1'b0);
    exp_q.push_back(8'(n));           exp_l.push_back(1'b0);
    exp_q.push_back(8'(next_ev >> 8)); exp_l.push_back(1'b0);
    exp_q.push_back(8'(next_ev));     exp_l.push_back(1'b0);
    for (int e = 0; e < n; e++) begin
      exp_q.push_back(8'(ev_len[next_ev + e])); exp_l.push_back(1'b0);
      for (int b = 0; b < ev_len[next_ev + e]; b++) begin
        exp_q.push_back(ev_data[ev_off[next_ev + e] + b]);
        exp_l.push_back(e == n - 1 && b == ev_len[next_ev + e] - 1);
      end
    end
    next_ev += n;
  endfunction

  task automatic send_event(int len, bit gaps);
    ev_off.push_back(ev_data.size());
    ev_len.push_back(len);
    @(posedge clk); #1;
    for (int b = 0; b < len; b++) begin
      logic [7:0] v;
      v = 8'($urandom);
      ev_data.push_back(v);
      in_valid = 1'b1; in_data = v; in_last = (b == len - 1);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
      in_valid = 1'b0;
      if (gaps && $urandom % 4 == 0) begin @(posedge clk); #1; end
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic compare(string req);
    int k, idx;
    bit ok;
    for (int w = 0; w < 20000 && got_q.size() < exp_q.size(); w++) @(negedge clk);
    chk(got_q.size() == exp_q.size(), req, "byte count", got_q.size(), exp_q.size());
    k = 0; ok = 1'b1; idx = -1;
    for (int i = 0; i < exp_q.size(); i++) begin
      if (i >= got_q.size() || got_q[i] !== exp_q[i] || got_l[i] !== exp_l[i]) begin
        if (ok) idx = i;
        ok = 1'b0;
      end
      if (exp_l[i]) begin
        chk(ok, req, $sformatf("packet %0d byte %0d", k, idx),
            (idx >= 0 && idx < got_q.size()) ? int'(got_q[idx]) : -1,
            (idx >= 0) ? int'(exp_q[idx]) : 0);
        k++; ok = 1'b1; idx = -1;
      end
    end
    exp_q.delete(); exp_l.delete(); got_q.delete(); got_l.delete();
  endtask

  task automatic run_packets(int cfg, int npk, bit gaps, string req);
    int n;
    cfg_pack = 4'(cfg);
    n = eff_of(cfg);
    for (int p = 0; p < npk; p++) begin
      dest_q.push_back(8'($urandom));
      for (int e = 0; e < n; e++) send_event(1 + $urandom % 16, gaps);
      build_packet(n, dest_q[dest_q.size() - 1]);
    end
    compare(req);
  endtask

  always @(negedge clk)
    if (rst_n && out_valid && out_ready) begin
      got_q.push_back(out_data);
      got_l.push_back(out_last);
    end

  initial forever begin
    @(posedge clk); #1;
    out_ready = rnd_ready ? ($urandom % 3 != 0) : ready_force;
  end

  initial forever begin
    @(posedge clk); #1;
    if (dest_q.size() > 0 && dest_en && (!rnd_dest || $urandom % 3 == 0)) begin
      dest_valid = 1'b1; dest_id = dest_q[0];
      @(negedge clk);
      while (!dest_ready) @(negedge clk);
      @(posedge clk); #1;
      dest_valid = 1'b0;
      void'(dest_q.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    chk(throttle == 1'b0, "R1", "throttle", throttle, 0);
    chk(dest_ready == 1'b0, "R1", "dest_ready", dest_ready, 0);

    run_packets(3, 2, 1'b0, "R4");
    run_packets(0, 3, 1'b0, "R2");
    run_packets(13, 1, 1'b0, "R2");

    // R3: three of four fragments present, destination waiting
    cfg_pack = 4'd4;
    dest_q.push_back(8'hA5);
    for (int e = 0; e < 3; e++) send_event(1 + $urandom % 16, 1'b0);
    repeat (30) @(negedge clk);
    chk(out_valid == 1'b0, "R3", "out_valid before last fragment", out_valid, 0);
    chk(dest_ready == 1'b0, "R3", "dest_ready before last fragment", dest_ready, 0);
    send_event(5, 1'b0);
    build_packet(4, 8'hA5);
    compare("R3");

    // R6/R7: complete events but no destination, then stalled output
    dest_en = 1'b0;
    cfg_pack = 4'd2;
    d = 8'h3C;
    dest_q.push_back(d);
    for (int e = 0; e < 2; e++) send_event(1 + $urandom % 16, 1'b0);
    build_packet(2, d);
    repeat (30) @(negedge clk);
    chk(out_valid == 1'b0, "R6", "out_valid without destination", out_valid, 0);
    chk(dest_ready == 1'b1, "R6", "dest_ready when events stored", dest_ready, 1);
    ready_force = 1'b0;
    dest_en = 1'b1;
    repeat (6) @(negedge clk);
    chk(out_valid == 1'b1 && out_data == d, "R7", "stalled header byte", out_data, d);
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b1 && out_data == d, "R7", "header held", out_data, d);
    ready_force = 1'b1;
    compare("R6");

    // R8/R9: fill with 16-byte fragments while output is blocked
    dest_en = 1'b0; ready_force = 1'b0;
    cfg_pack = 4'd8;
    for (int e = 0; e < 8; e++) send_event(16, 1'b0);
    repeat (3) @(negedge clk);
    chk(throttle == 1'b0, "R8", "throttle at 128 bytes", throttle, 0);
    send_event(16, 1'b0);
    repeat (3) @(negedge clk);
    chk(throttle == 1'b1, "R8", "throttle at 144 bytes", throttle, 1);
    for (int e = 0; e < 7; e++) send_event(16, 1'b0);
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R9", "in_ready at 256 bytes", in_ready, 0);
    build_packet(8, 8'h11);
    build_packet(8, 8'h22);
    dest_q.push_back(8'h11);
    ready_force = 1'b1; dest_en = 1'b1;
    for (int w = 0; w < 2000 && got_q.size() < 140; w++) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(throttle == 1'b1, "R8", "hysteresis at 128 bytes", throttle, 1);
    chk(in_ready == 1'b1, "R9", "in_ready after drain", in_ready, 1);
    dest_q.push_back(8'h22);
    compare("R9");
    repeat (3) @(negedge clk);
    chk(throttle == 1'b0, "R8", "throttle after full drain", throttle, 0);

    // R5/R2: random traffic with overlapping input and output
    rnd_ready = 1'b1; rnd_dest = 1'b1;
    for (int r = 0; r < 25; r++) run_packets($urandom % 16, 1 + $urandom % 3, 1'b1, "R5");
    rnd_ready = 1'b0; ready_force = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule